// File: doc/BRIEF.md
# Signed Multiply Execution Unit with HI/LO

This unit executes the multiply group of a 32-bit load/store core. Each cycle it may accept one 32-bit instruction word together with the two register-file read values chosen by that word's source fields. It recognises four operations. The first is a two-operand signed multiply that deposits the whole 64-bit product into a private HI/LO register pair. Two move operations copy HI or LO into a general register. A three-operand multiply sends only the low half of the product straight to a destination register and leaves HI and LO alone.

Results leave through a single write-back port: a strobe, a 5-bit register index and 32 bits of data. The parameter `OUT_REG` selects whether that port is registered, with results one cycle after the instruction, or combinational, with results in the same cycle. Some hardware cannot read HI/LO right after a multiply. The parameter `MIN_GAP` sets how many instructions must separate a two-operand multiply from a following move. A move issued sooner still returns the fresh value, but the unit raises `earlyRead` alongside it so the core can trap or count the violation.

Top module: `mul_hilo_unit`

## Requirements
- R1: After reset HI and LO hold zero and the write-back strobe and `earlyRead` are low, so a move issued first returns zero.
- R2: A two-operand multiply (opcode bits 31:26 = 0x00, function bits 5:0 = 0x18, sources in bits 25:21 and 20:16) stores bits 63:32 of the signed 64-bit product in HI and bits 31:0 in LO. The update happens at the clock edge that accepts it, and the instruction produces no write-back.
- R3: Opcode 0x00 with function 0x12 writes LO, and with function 0x10 writes HI, to the register in bits 15:11. The source fields of these moves are ignored.
- R4: Opcode 0x1C with function 0x02 writes the low 32 bits of the signed product of the two sources to the register in bits 15:11.
- R5: The three-operand multiply leaves HI and LO unchanged.
- R6: An operation whose destination field is 0 produces no write-back strobe.
- R7: An instruction word outside the four operations, or a cycle with `instrValid` low, produces no write-back and leaves HI and LO unchanged.
- R8: With `OUT_REG`=1 (default), `wbValid`, `wbIdx`, `wbData` and `earlyRead` for an instruction appear in the cycle after it is accepted. Only that cycle carries them.
- R9: A move accepted with fewer than `MIN_GAP` (default 1) accepted instructions between it and the latest two-operand multiply raises `earlyRead` with the same timing as its write-back. It still returns the updated HI/LO.
- R10: Cycles with `instrValid` low do not count as separating instructions for R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| rsData | input | 32 | Register value selected by bits 25:21 |
| rtData | input | 32 | Register value selected by bits 20:16 |
| wbValid | output | 1 | Write-back strobe |
| wbIdx | output | 5 | Destination register index |
| wbData | output | 32 | Write-back data |
| earlyRead | output | 1 | Move issued inside the HI/LO read gap |

## Verification
With the default registered port, every instruction's write-back, and the lack of one, is due exactly one cycle after the accepting edge. HI/LO changes show up in the moves that follow. The driver stamps each expected item with the cycle in which the instruction was presented. The monitor samples at falling edges and takes an item only once the cycle counter has moved past that stamp, so each result is compared in the single cycle it is due. Idle and unsupported cycles push items that expect a silent port, which catches strobes that come early or late.

// File: rtl/mulu_pkg.sv
package mulu_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;

  localparam logic [5:0] OP_BASE   = 6'h00;
  localparam logic [5:0] OP_EXT    = 6'h1C;
  localparam logic [5:0] FN_MULT   = 6'h18;
  localparam logic [5:0] FN_MFHI   = 6'h10;
  localparam logic [5:0] FN_MFLO   = 6'h12;
  localparam logic [5:0] FN_MUL3   = 6'h02;

  typedef struct packed {
    logic              loadHiLo;
    logic              selHi;
    logic              selLo;
    logic              selMul;
    logic              wbEn;
    logic [RIDX_W-1:0] wbIdx;
    logic              early;
  } ctlStrobeT;
endpackage

// File: rtl/mulu_ctrl.sv
module mulu_ctrl
  import mulu_pkg::*;
#(
  parameter int MIN_GAP = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instrValid,
  input  logic [XLEN-1:0] instr,
  output ctlStrobeT       ctl
);
  localparam int GAP_W = (MIN_GAP > 0) ? $clog2(MIN_GAP + 1) : 1;
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(MIN_GAP);

  logic [5:0]        opField;
  logic [5:0]        fnField;
  logic [RIDX_W-1:0] rdField;
  logic              isMult, isMfhi, isMflo, isMul3, isMove;
  logic [GAP_W-1:0]  gapQ;
  logic              unusedFields;

  assign opField      = instr[31:26];
  assign fnField      = instr[5:0];
  assign rdField      = instr[15:11];
  assign unusedFields = ^{instr[25:16], instr[10:6]};

  always_comb begin
    isMult = instrValid && opField == OP_BASE && fnField == FN_MULT;
    isMfhi = instrValid && opField == OP_BASE && fnField == FN_MFHI;
    isMflo = instrValid && opField == OP_BASE && fnField == FN_MFLO;
    isMul3 = instrValid && opField == OP_EXT  && fnField == FN_MUL3;
    isMove = isMfhi || isMflo;
  end

  // instructions seen since the latest two-operand multiply, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapQ <= GAP_SAT;
    end else if (isMult) begin
      gapQ <= '0;
    end else if (instrValid && gapQ < GAP_SAT) begin
      gapQ <= gapQ + 1'b1;
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.loadHiLo = isMult;
    ctl.selHi    = isMfhi;
    ctl.selLo    = isMflo;
    ctl.selMul   = isMul3;
    ctl.wbEn     = (isMove || isMul3) && rdField != '0;
    ctl.wbIdx    = rdField;
    ctl.early    = isMove && gapQ < GAP_SAT;
  end

  // R3
  one_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.selHi, ctl.selLo, ctl.selMul, ctl.loadHiLo}));

  // R9
  early_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.early |-> (ctl.selHi || ctl.selLo));

  // R2
  mult_no_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadHiLo |-> !ctl.wbEn);

  // R10
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> $stable(gapQ));
endmodule

// File: rtl/mulu_dpath.sv
module mulu_dpath
  import mulu_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         ctl,
  input  logic [XLEN-1:0]   rsData,
  input  logic [XLEN-1:0]   rtData,
  output logic              wbValid,
  output logic [RIDX_W-1:0] wbIdx,
  output logic [XLEN-1:0]   wbData,
  output logic              earlyRead
);
  localparam int PROD_W = 2 * XLEN;

  logic [PROD_W-1:0] prodFull;
  logic [XLEN-1:0]   hiQ, loQ;
  logic [XLEN-1:0]   resultD;

  always_comb begin
    prodFull = {{XLEN{rsData[XLEN-1]}}, rsData} * {{XLEN{rtData[XLEN-1]}}, rtData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiQ <= '0;
      loQ <= '0;
    end else if (ctl.loadHiLo) begin
      hiQ <= prodFull[PROD_W-1:XLEN];
      loQ <= prodFull[XLEN-1:0];
    end
  end

  // HI and LO read here are already the updated values (early reads see them)
  always_comb begin
    resultD = prodFull[XLEN-1:0];
    if (ctl.selHi)      resultD = hiQ;
    else if (ctl.selLo) resultD = loQ;
  end

  generate
    if (OUT_REG) begin : gRegOut
      always_ff @(posedge clk) begin
        if (!rstN) begin
          wbValid   <= 1'b0;
          wbIdx     <= '0;
          wbData    <= '0;
          earlyRead <= 1'b0;
        end else begin
          wbValid   <= ctl.wbEn;
          wbIdx     <= ctl.wbIdx;
          wbData    <= resultD;
          earlyRead <= ctl.early;
        end
      end
    end else begin : gCombOut
      always_comb begin
        wbValid   = ctl.wbEn;
        wbIdx     = ctl.wbIdx;
        wbData    = resultD;
        earlyRead = ctl.early;
      end
    end
  endgenerate

  // R5 R7
  hilo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadHiLo |=> ($stable(hiQ) && $stable(loQ)));

  // R6
  wb_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> wbIdx != '0);
endmodule

// File: rtl/mul_hilo_unit.sv
module mul_hilo_unit
  import mulu_pkg::*;
#(
  parameter bit OUT_REG = 1'b1,
  parameter int MIN_GAP = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  logic [31:0] instr,
  input  logic [31:0] rsData,
  input  logic [31:0] rtData,
  output logic        wbValid,
  output logic [4:0]  wbIdx,
  output logic [31:0] wbData,
  output logic        earlyRead
);
  ctlStrobeT ctl;

  mulu_ctrl #(.MIN_GAP(MIN_GAP)) uCtrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr), .ctl(ctl)
  );

  mulu_dpath #(.OUT_REG(OUT_REG)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rsData(rsData), .rtData(rtData),
    .wbValid(wbValid), .wbIdx(wbIdx), .wbData(wbData), .earlyRead(earlyRead)
  );
endmodule

// File: tb/tb_mul_hilo_unit.sv
`timescale 1ns/1ps
module tb_mul_hilo_unit;
  localparam int MIN_GAP = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rsData = '0;
  logic [31:0] rtData = '0;
  logic        wbValid;
  logic [4:0]  wbIdx;
  logic [31:0] wbData;
  logic        earlyRead;

  always #4 clk = ~clk;

  mul_hilo_unit #(.OUT_REG(1'b1), .MIN_GAP(MIN_GAP)) dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr),
    .rsData(rsData), .rtData(rtData), .wbValid(wbValid), .wbIdx(wbIdx),
    .wbData(wbData), .earlyRead(earlyRead)
  );

  typedef struct {
    int          stamp;
    logic        v;
    logic [4:0]  idx;
    logic [31:0] data;
    logic        early;
    string       req;
  } expT;

  expT expQ[$];
  int  checks = 0;
  int  failures = 0;
  int  cyc = 0;
  bit  finished = 0;

  logic [31:0] mHi = '0, mLo = '0;
  int          mGap = MIN_GAP;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] encR(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'h00, fn};
  endfunction

  function automatic logic [63:0] sprod(logic [31:0] a, logic [31:0] b);
    longint pa, pb;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    return 64'(pa * pb);
  endfunction

  // driver: presents one cycle's input and pushes what the port must show next cycle (R8)
  task automatic issue(input logic vld, input logic [31:0] w, input logic [31:0] a,
                       input logic [31:0] b, input string req);
    expT e;
    logic [5:0] op, fn;
    logic [63:0] p;
    @(posedge clk);
    #1;
    instrValid = vld; instr = w; rsData = a; rtData = b;
    op = w[31:26]; fn = w[5:0];
    p = sprod(a, b);
    e.stamp = cyc; e.v = 1'b0; e.idx = w[15:11]; e.data = '0; e.early = 1'b0; e.req = req;
    if (vld && op == 6'h00 && (fn == 6'h10 || fn == 6'h12)) begin
      e.v     = (w[15:11] != 0);
      e.data  = (fn == 6'h10) ? mHi : mLo;
      e.early = (mGap < MIN_GAP);
    end else if (vld && op == 6'h1C && fn == 6'h02) begin
      e.v    = (w[15:11] != 0);
      e.data = p[31:0];
    end
    if (vld && op == 6'h00 && fn == 6'h18) begin
      mHi = p[63:32]; mLo = p[31:0]; mGap = 0;
    end else if (vld && mGap < MIN_GAP) begin
      mGap++;
    end
    expQ.push_back(e);
  endtask

  // monitor: pops items whose due cycle has come
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0 && expQ[0].stamp < cyc) begin
      expT e;
      e = expQ.pop_front();
      checks++;
      if (wbValid !== e.v || earlyRead !== e.early ||
          (e.v && (wbIdx !== e.idx || wbData !== e.data))) begin
        failures++;
        $display("FAIL %s: got v=%b idx=%0d data=%h early=%b exp v=%b idx=%0d data=%h early=%b",
                 e.req, wbValid, wbIdx, wbData, earlyRead, e.v, e.idx, e.data, e.early);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog: got hung run exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state at the port
    if (wbValid !== 1'b0 || earlyRead !== 1'b0) begin
      failures++;
      $display("FAIL R1: got wbValid=%b earlyRead=%b exp 0 0", wbValid, earlyRead);
    end
    @(posedge clk); #1 rstN = 1'b1;

    // R1: moves right after reset read zero, no early flag
    issue(1, encR(5'd0, 5'd0, 5'd5, 6'h10), 32'hAAAA_AAAA, 32'h5555_5555, "R1 mfhi after reset");
    issue(1, encR(5'd0, 5'd0, 5'd6, 6'h12), 0, 0, "R1 mflo after reset");

    // R2: two-operand multiply, no write-back
    issue(1, 32'h0066_0018, 32'hFFFF_FFF9, 32'd123456789, "R2 mult no wb");
    issue(1, 32'h0000_0000, 32'h1, 32'h1, "R7 unsupported sll word");
    issue(1, 32'h0000_1012, 0, 0, "R3 mflo after gap");
    issue(1, encR(5'd7, 5'd9, 5'd3, 6'h10), 32'h1234, 32'h5678, "R3 mfhi fields ignored");

    // R9: move straight after multiply is flagged yet sees new value
    issue(1, 32'h0066_0018, 32'h8000_0000, 32'h8000_0000, "R2 mult min*min");
    issue(1, encR(5'd0, 5'd0, 5'd4, 6'h10), 0, 0, "R9 early mfhi");
    issue(1, encR(5'd0, 5'd0, 5'd4, 6'h12), 0, 0, "R2 mflo of min*min");

    // R10: idle cycle does not separate
    issue(1, 32'h0066_0018, 32'h7FFF_FFFF, 32'hFFFF_FFFE, "R2 mult mixed sign");
    issue(0, encR(5'd0, 5'd0, 5'd8, 6'h12), 0, 0, "R7 idle cycle");
    issue(1, encR(5'd0, 5'd0, 5'd8, 6'h12), 0, 0, "R10 early after idle");

    // R4 R5: three-operand multiply leaves HI/LO
    issue(1, 32'h7085_1002, 32'hFFFF_FFFD, 32'h7FFF_FFFF, "R4 mul low half");
    issue(1, 32'h7085_1002, 32'h0001_0000, 32'h0001_0000, "R4 mul overflow wraps");
    issue(1, encR(5'd0, 5'd0, 5'd9, 6'h10), 0, 0, "R5 hi unchanged by mul");
    issue(1, encR(5'd0, 5'd0, 5'd9, 6'h12), 0, 0, "R5 lo unchanged by mul");

    // R6: destination zero suppressed
    issue(1, 32'h7085_0002, 32'd6, 32'd7, "R6 mul to r0");
    issue(1, encR(5'd0, 5'd0, 5'd0, 6'h12), 0, 0, "R6 mflo to r0");

    // R7: unsupported encodings change nothing
    issue(1, {6'h1C, 5'd4, 5'd5, 5'd2, 5'd0, 6'h03}, 32'd9, 32'd9, "R7 ext op other fn");
    issue(1, {6'h00, 5'd4, 5'd5, 5'd2, 5'd0, 6'h19}, 32'd9, 32'd9, "R7 unsigned mult absent");
    issue(1, encR(5'd0, 5'd0, 5'd10, 6'h12), 0, 0, "R7 lo unchanged");
    issue(1, encR(5'd0, 5'd0, 5'd11, 6'h10), 0, 0, "R7 hi unchanged");

    // R8: back-to-back results each land in their own cycle
    issue(1, 32'h7085_1002, 32'd3, 32'd5, "R8 back-to-back a");
    issue(1, 32'h7085_1802, 32'd4, 32'd5, "R8 back-to-back b");
    issue(0, 0, 0, 0, "R8 trailing idle");

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule